// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage Pipeline

This block looks at the instruction that currently sits in the decode/register-read stage of an in-order, five-stage pipeline. For each of its two source operands it picks where the value should come from: the register file, or a result that is still in flight in the execute, memory or writeback stage. It also raises a stall when a load in the execute stage produces a register that the decoding instruction needs. Load data only exists one stage later, so no forwarding path can supply that value in time.

Which instruction bits name a source register depends on the opcode. The block therefore decodes the opcode itself and compares only the fields that really are register reads. Immediate and offset bits are never compared. Register 0 always reads as zero, so it is never forwarded and never causes a stall. When more than one later stage will write the same register, the nearest stage wins, because it holds the youngest value. The block is purely combinational: the pipeline registers, the register file and the operand multiplexers are outside it.

Top module: `hzd_unit`

## Requirements
- R1: Source fields are decoded per opcode, with field HI = bits [27:24], MID = bits [23:20] and LO = bits [3:0].
  - Opcodes 0x0, 0x1 and 0xA: operand A is MID and operand B is LO.
  - Opcodes 0x2 and 0x3: operand A is MID and there is no operand B.
  - Opcode 0x4: operand A is MID and operand B is HI.
  - Opcodes 0x5 and 0x8: operand A is HI and operand B is MID.
  - Opcode 0x6: operand A is HI and there is no operand B.
- R2: A source or destination equal to register 0 never produces a forward select other than 0 and never produces a stall.
- R3: A later-stage instruction counts as a producer only while its write flag is high.
- R4: Select codes are 0 = register file, 1 = execute result, 2 = memory-stage ALU value, 3 = memory-stage loaded data and 4 = writeback value. When several producers match, execute beats memory, memory beats writeback, and writeback beats the register file.
- R5: A memory-stage match gives code 3 when the memory-stage load flag is high and code 2 otherwise.
- R6: `stall` and `bubble` are both high when the execute-stage instruction writes a nonzero register, is a load, and that register equals a decoded source.
- R7: While `flush` is high, `stall` and `bubble` are low, and the selects are unaffected.
- R8: Opcodes 0x7, 0x9 and 0xB to 0xF read no register. Fields that carry immediates or offsets are never compared. Both give select 0 on that operand.
- R9: All outputs follow the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idOpcode | input | 4 | Opcode of the decoding instruction, bits [31:28] |
| idFieldHi | input | 4 | Decoding instruction bits [27:24] |
| idFieldMid | input | 4 | Decoding instruction bits [23:20] |
| idFieldLo | input | 4 | Decoding instruction bits [3:0] |
| exDst | input | 4 | Destination register of the execute-stage instruction |
| exWrites | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| memDst | input | 4 | Destination register of the memory-stage instruction |
| memWrites | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| wbDst | input | 4 | Destination register of the writeback-stage instruction |
| wbWrites | input | 1 | Writeback-stage instruction writes a register |
| flush | input | 1 | A taken branch is clearing the front of the pipe this cycle |
| selA | output | 3 | Forward select for operand A (codes in R4) |
| selB | output | 3 | Forward select for operand B (codes in R4) |
| stall | output | 1 | Hold the PC and the fetch/decode buffer |
| bubble | output | 1 | Insert a no-op into the execute stage |

## Verification
Two functions can fall in the same cycle: a load-use stall and a flush. This happens when a taken branch in execute coincides with a dependent instruction in decode behind a load. The bench provokes it by presenting a load in execute that matches a decoded source while `flush` is high. It judges the result by requiring `stall` and `bubble` to drop while the selects keep the values they would have without the flush. A second overlap is the multi-stage write-after-write case. Here the same register is written in all three later stages and then the producers are removed one at a time, nearest first. Each step must expose the next priority code.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_W = 4;
  localparam int OPC_W = 4;
  localparam int SEL_W = 3;

  localparam logic [OPC_W-1:0] OP_ADD   = 4'h0;
  localparam logic [OPC_W-1:0] OP_NAND  = 4'h1;
  localparam logic [OPC_W-1:0] OP_ADDI  = 4'h2;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h3;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h4;
  localparam logic [OPC_W-1:0] OP_BREQ  = 4'h5;
  localparam logic [OPC_W-1:0] OP_JLINK = 4'h6;
  localparam logic [OPC_W-1:0] OP_BRGT  = 4'h8;
  localparam logic [OPC_W-1:0] OP_SHIFT = 4'hA;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_HI   = 2'd1,
    FLD_MID  = 2'd2,
    FLD_LO   = 2'd3
  } fieldSel_t;

  typedef enum logic [SEL_W-1:0] {
    FWD_REG      = 3'd0,
    FWD_EX       = 3'd1,
    FWD_MEM_ALU  = 3'd2,
    FWD_MEM_LOAD = 3'd3,
    FWD_WB       = 3'd4
  } fwdSel_t;

  // Strobes from control to datapath: which instruction field feeds each operand.
  typedef struct packed {
    fieldSel_t srcA;
    fieldSel_t srcB;
  } srcStrobes_t;
endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int OPW = OPC_W,
  parameter int NSRC = 2
) (
  input  logic [OPW-1:0]  idOpcode,
  input  logic [NSRC-1:0] loadHit,
  input  logic            flush,
  output srcStrobes_t     strobes,
  output logic            stall,
  output logic            bubble
);
  // Opcode-dependent register-read map.
  always_comb begin
    strobes.srcA = FLD_NONE;
    strobes.srcB = FLD_NONE;
    case (idOpcode)
      OP_ADD, OP_NAND, OP_SHIFT: begin
        strobes.srcA = FLD_MID;
        strobes.srcB = FLD_LO;
      end
      OP_ADDI, OP_LOAD: begin
        strobes.srcA = FLD_MID;
      end
      OP_STORE: begin
        strobes.srcA = FLD_MID;
        strobes.srcB = FLD_HI;
      end
      OP_BREQ, OP_BRGT: begin
        strobes.srcA = FLD_HI;
        strobes.srcB = FLD_MID;
      end
      OP_JLINK: begin
        strobes.srcA = FLD_HI;
      end
      default: ;
    endcase
  end

  // A flush already empties the front of the pipe, so it takes precedence.
  logic loadUse;
  assign loadUse = |loadHit;
  assign stall   = loadUse && !flush;
  assign bubble  = loadUse && !flush;
endmodule

// File: rtl/hzd_dpath.sv
module hzd_dpath
  import hzd_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NSRC = 2
) (
  input  srcStrobes_t     strobes,
  input  logic [RW-1:0]   idFieldHi,
  input  logic [RW-1:0]   idFieldMid,
  input  logic [RW-1:0]   idFieldLo,
  input  logic [RW-1:0]   exDst,
  input  logic            exWrites,
  input  logic            exIsLoad,
  input  logic [RW-1:0]   memDst,
  input  logic            memWrites,
  input  logic            memIsLoad,
  input  logic [RW-1:0]   wbDst,
  input  logic            wbWrites,
  output fwdSel_t         selOut [NSRC],
  output logic [NSRC-1:0] loadHit
);
  genvar g;
  for (g = 0; g < NSRC; g++) begin : gOp
    fieldSel_t     fs;
    logic [RW-1:0] srcReg;
    logic          live;
    logic          hitEx;
    logic          hitMem;
    logic          hitWb;
    fwdSel_t       sel;

    assign fs = (g == 0) ? strobes.srcA : strobes.srcB;

    always_comb begin
      case (fs)
        FLD_HI:  srcReg = idFieldHi;
        FLD_MID: srcReg = idFieldMid;
        FLD_LO:  srcReg = idFieldLo;
        default: srcReg = '0;
      endcase
    end

    // Register zero is hard-wired, so it is never a live dependency.
    assign live   = (fs != FLD_NONE) && (srcReg != '0);
    assign hitEx  = live && exWrites  && (exDst  == srcReg);
    assign hitMem = live && memWrites && (memDst == srcReg);
    assign hitWb  = live && wbWrites  && (wbDst  == srcReg);

    always_comb begin
      if (hitEx)       sel = FWD_EX;
      else if (hitMem) sel = memIsLoad ? FWD_MEM_LOAD : FWD_MEM_ALU;
      else if (hitWb)  sel = FWD_WB;
      else             sel = FWD_REG;
    end

    assign selOut[g]  = sel;
    assign loadHit[g] = hitEx && exIsLoad;
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
(
  input  logic [OPC_W-1:0] idOpcode,
  input  logic [REG_W-1:0] idFieldHi,
  input  logic [REG_W-1:0] idFieldMid,
  input  logic [REG_W-1:0] idFieldLo,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWrites,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrites,
  input  logic             memIsLoad,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrites,
  input  logic             flush,
  output logic [SEL_W-1:0] selA,
  output logic [SEL_W-1:0] selB,
  output logic             stall,
  output logic             bubble
);
  localparam int NSRC = 2;

  srcStrobes_t     strobes;
  logic [NSRC-1:0] loadHit;
  fwdSel_t         selVec [NSRC];

  hzd_ctrl #(.OPW(OPC_W), .NSRC(NSRC)) u_ctrl (
    .idOpcode (idOpcode),
    .loadHit  (loadHit),
    .flush    (flush),
    .strobes  (strobes),
    .stall    (stall),
    .bubble   (bubble)
  );

  hzd_dpath #(.RW(REG_W), .NSRC(NSRC)) u_dpath (
    .strobes    (strobes),
    .idFieldHi  (idFieldHi),
    .idFieldMid (idFieldMid),
    .idFieldLo  (idFieldLo),
    .exDst      (exDst),
    .exWrites   (exWrites),
    .exIsLoad   (exIsLoad),
    .memDst     (memDst),
    .memWrites  (memWrites),
    .memIsLoad  (memIsLoad),
    .wbDst      (wbDst),
    .wbWrites   (wbWrites),
    .selOut     (selVec),
    .loadHit    (loadHit)
  );

  assign selA = SEL_W'(selVec[0]);
  assign selB = SEL_W'(selVec[1]);
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker
  import hzd_pkg::*;
(
  input logic [OPC_W-1:0] idOpcode,
  input logic [REG_W-1:0] exDst,
  input logic             exWrites,
  input logic             exIsLoad,
  input logic [REG_W-1:0] memDst,
  input logic             memWrites,
  input logic             memIsLoad,
  input logic [REG_W-1:0] wbDst,
  input logic             wbWrites,
  input logic             flush,
  input logic [SEL_W-1:0] selA,
  input logic [SEL_W-1:0] selB,
  input logic             stall,
  input logic             bubble
);
  always_comb begin
    // R6: a stall needs a nonzero-writing load in execute
    p_stall_needs_load_r6: assert (!stall || (exIsLoad && exWrites && exDst != '0))
      else $error("stall without a load producer");
    // R6: stall and bubble rise together
    p_stall_bubble_pair_r6: assert (stall == bubble)
      else $error("stall and bubble disagree");
    // R7: flush suppresses the stall
    p_flush_wins_r7: assert (!(flush && (stall || bubble)))
      else $error("stall during flush");
    // R3 and R2: an execute forward needs a real producer
    p_ex_sel_valid_r3: assert ((selA != 3'd1 && selB != 3'd1) || (exWrites && exDst != '0))
      else $error("execute forward without producer");
    // R5: memory load code only when the memory stage holds a load
    p_memload_sel_r5: assert ((selA != 3'd3 && selB != 3'd3) || (memIsLoad && memWrites && memDst != '0))
      else $error("load code without memory load");
    // R3: writeback forward needs a real producer
    p_wb_sel_valid_r3: assert ((selA != 3'd4 && selB != 3'd4) || (wbWrites && wbDst != '0))
      else $error("writeback forward without producer");
    // R4: only defined select codes appear
    p_sel_range_r4: assert (selA <= 3'd4 && selB <= 3'd4)
      else $error("undefined select code");
    // R8: opcodes without register reads never forward
    p_nosrc_reg_r8: assert (!(idOpcode == 4'h7 || idOpcode == 4'h9 || idOpcode >= 4'hB) || (selA == 3'd0 && selB == 3'd0 && !stall))
      else $error("forward on an opcode with no source");
  end
endmodule

bind hzd_unit hzd_checker u_chk (
  .idOpcode  (idOpcode),
  .exDst     (exDst),
  .exWrites  (exWrites),
  .exIsLoad  (exIsLoad),
  .memDst    (memDst),
  .memWrites (memWrites),
  .memIsLoad (memIsLoad),
  .wbDst     (wbDst),
  .wbWrites  (wbWrites),
  .flush     (flush),
  .selA      (selA),
  .selB      (selB),
  .stall     (stall),
  .bubble    (bubble)
);

// File: tb/sim_hzd_unit.sv
module sim_hzd_unit;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [3:0] idOpcode, idFieldHi, idFieldMid, idFieldLo;
  logic [3:0] exDst, memDst, wbDst;
  logic exWrites, exIsLoad, memWrites, memIsLoad, wbWrites, flush;
  logic [2:0] selA, selB;
  logic stall, bubble;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  hzd_unit u0 (
    .idOpcode(idOpcode), .idFieldHi(idFieldHi), .idFieldMid(idFieldMid), .idFieldLo(idFieldLo),
    .exDst(exDst), .exWrites(exWrites), .exIsLoad(exIsLoad),
    .memDst(memDst), .memWrites(memWrites), .memIsLoad(memIsLoad),
    .wbDst(wbDst), .wbWrites(wbWrites), .flush(flush),
    .selA(selA), .selB(selB), .stall(stall), .bubble(bubble)
  );

  // Reference: which register each operand reads, -1 when none.
  function automatic int srcOf(input int op, input int which,
                               input int hi, input int mid, input int lo);
    int a = -1, b = -1;
    if (op == 0 || op == 1 || op == 10) begin a = mid; b = lo; end
    else if (op == 2 || op == 3) a = mid;
    else if (op == 4) begin a = mid; b = hi; end
    else if (op == 5 || op == 8) begin a = hi; b = mid; end
    else if (op == 6) a = hi;
    return (which == 0) ? a : b;
  endfunction

  function automatic int selOf(input int r);
    if (r <= 0) return 0;
    if (exWrites && int'(exDst) == r) return 1;
    if (memWrites && int'(memDst) == r) return memIsLoad ? 3 : 2;
    if (wbWrites && int'(wbDst) == r) return 4;
    return 0;
  endfunction

  task automatic check(input string req);
    int ra, rb, ea, eb;
    bit es;
    ra = srcOf(int'(idOpcode), 0, int'(idFieldHi), int'(idFieldMid), int'(idFieldLo));
    rb = srcOf(int'(idOpcode), 1, int'(idFieldHi), int'(idFieldMid), int'(idFieldLo));
    ea = selOf(ra);
    eb = selOf(rb);
    es = !flush && exWrites && exIsLoad && exDst != 0 &&
         ((ra > 0 && int'(exDst) == ra) || (rb > 0 && int'(exDst) == rb));
    checks++;
    if (int'(selA) != ea || int'(selB) != eb || stall != es || bubble != es) begin
      fails++;
      $display("FAIL %s: selA=%0d selB=%0d stall=%0d bubble=%0d expected %0d %0d %0d %0d",
               req, selA, selB, stall, bubble, ea, eb, es, es);
    end
  endtask

  task automatic setId(input int op, input int hi, input int mid, input int lo);
    idOpcode = 4'(op); idFieldHi = 4'(hi); idFieldMid = 4'(mid); idFieldLo = 4'(lo);
  endtask

  task automatic setEx(input int d, input bit w, input bit ld);
    exDst = 4'(d); exWrites = w; exIsLoad = ld;
  endtask

  task automatic setMem(input int d, input bit w, input bit ld);
    memDst = 4'(d); memWrites = w; memIsLoad = ld;
  endtask

  task automatic setWb(input int d, input bit w);
    wbDst = 4'(d); wbWrites = w;
  endtask

  // Apply after a rising edge, sample a quarter period later (R9: same cycle).
  task automatic step(input string req);
    #(PERIOD/4);
    check(req);
    @(posedge clk);
  endtask

  task automatic expectFixed(input string req, input int ea, input int eb, input bit es);
    checks++;
    if (int'(selA) != ea || int'(selB) != eb || stall != es || bubble != es) begin
      fails++;
      $display("FAIL %s: selA=%0d selB=%0d stall=%0d expected %0d %0d %0d",
               req, selA, selB, stall, ea, eb, es);
    end
  endtask

  initial begin
    setId(0, 0, 0, 0); setEx(0, 0, 0); setMem(0, 0, 0); setWb(0, 0); flush = 0;
    @(posedge clk);
    #(PERIOD/4); expectFixed("R2 idle", 0, 0, 0); @(posedge clk);

    // R1 / R9: ADD reads MID and LO
    setId(0, 1, 2, 3); setEx(2, 1, 0);
    #(PERIOD/4); expectFixed("R9 same-cycle", 1, 0, 0); @(posedge clk);
    setMem(3, 1, 1); step("R5 mem load");
    #(PERIOD/4); expectFixed("R5 code3", 1, 3, 0); @(posedge clk);
    setMem(3, 1, 0);
    #(PERIOD/4); expectFixed("R5 code2", 1, 2, 0); @(posedge clk);

    // R4: same register in all three later stages
    setId(1, 0, 7, 0); setEx(7, 1, 0); setMem(7, 1, 0); setWb(7, 1);
    #(PERIOD/4); expectFixed("R4 ex wins", 1, 0, 0); @(posedge clk);
    setEx(7, 0, 0);
    #(PERIOD/4); expectFixed("R4 mem wins", 2, 0, 0); @(posedge clk);
    setMem(7, 0, 0);
    #(PERIOD/4); expectFixed("R4 wb", 4, 0, 0); @(posedge clk);
    setWb(7, 0);
    #(PERIOD/4); expectFixed("R3 no writer", 0, 0, 0); @(posedge clk);

    // R2: register 0 never forwarded or stalled
    setId(0, 5, 0, 0); setEx(0, 1, 1); setMem(0, 1, 0); setWb(0, 1);
    #(PERIOD/4); expectFixed("R2 zero", 0, 0, 0); @(posedge clk);

    // R6 load-use, then R7 flush overlap
    setId(10, 1, 2, 4); setEx(4, 1, 1); setMem(0, 0, 0); setWb(2, 1);
    #(PERIOD/4); expectFixed("R6 load use", 4, 1, 1); @(posedge clk);
    flush = 1;
    #(PERIOD/4); expectFixed("R7 flush wins", 4, 1, 0); @(posedge clk);
    flush = 0;

    // R1: store reads MID (A) and HI (B)
    setId(4, 5, 6, 9); setEx(5, 1, 0); setWb(6, 1);
    #(PERIOD/4); expectFixed("R1 store", 4, 1, 0); @(posedge clk);
    setEx(5, 1, 1);
    #(PERIOD/4); expectFixed("R6 store data", 4, 1, 1); @(posedge clk);
    // R1: branch reads HI (A) and MID (B)
    setId(5, 7, 8, 0); setEx(7, 1, 0); setWb(0, 0);
    #(PERIOD/4); expectFixed("R1 branch", 1, 0, 0); @(posedge clk);
    // R1: jump-and-link reads HI only
    setId(6, 9, 10, 0); setEx(10, 1, 0);
    #(PERIOD/4); expectFixed("R1 jlink mid", 0, 0, 0); @(posedge clk);
    setEx(9, 1, 0);
    #(PERIOD/4); expectFixed("R1 jlink hi", 1, 0, 0); @(posedge clk);

    // R8: immediates and no-source opcodes
    setId(2, 1, 4, 2); setEx(2, 1, 1); setMem(1, 1, 0);
    #(PERIOD/4); expectFixed("R8 addi imm", 0, 0, 0); @(posedge clk);
    setId(9, 2, 2, 2); setMem(2, 1, 0); setWb(2, 1);
    #(PERIOD/4); expectFixed("R8 lea", 0, 0, 0); @(posedge clk);
    setId(7, 2, 2, 2);
    #(PERIOD/4); expectFixed("R8 halt", 0, 0, 0); @(posedge clk);
    setId(15, 2, 2, 2);
    #(PERIOD/4); expectFixed("R8 reserved", 0, 0, 0); @(posedge clk);

    // Mixed patterns against the reference model
    for (int i = 0; i < 600; i++) begin
      setId(int'($urandom_range(15)), int'($urandom_range(7)), int'($urandom_range(7)), int'($urandom_range(7)));
      setEx(int'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      setMem(int'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      setWb(int'($urandom_range(7)), 1'($urandom_range(1)));
      flush = ($urandom_range(7) == 0);
      step("R4 mixed");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule